// File: doc/BRIEF.md
# Burst Address Generator for a Synchronous SRAM

This block produces the access address of a pipelined synchronous SRAM. When a new access starts, it captures an external address. On each following advance request it steps only the two lowest address bits through a four-beat burst. The bits above them keep the value captured at the start.

A mode input picks one of two beat orders. In linear order the offset is added to the start value modulo four. In interleaved order the offset is XORed with the start value. The block stores a two-bit offset from the captured start, not the stepped address itself. The start value, the offset and the mode therefore fix every beat, and a mode change takes effect on the very next beat.

Advance requests step the offset whether or not the chip is selected. A load request starts a new access only when the chip-select-valid flag is high. A low clock enable freezes all state.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the stored start address and offset clear, so `addr_out` reads all zeros after that edge.
- R2: At an edge with `clk_en`=1, `adv_ld`=0 and `sel_valid`=1, the block captures `ext_addr` and clears the offset, so `addr_out` equals that `ext_addr` after the edge.
- R3: At an edge with `clk_en`=1 and `adv_ld`=1, `addr_out[ADDR_W-1:2]` keeps its value.
- R4: With `mode`=0 (linear), `addr_out[1:0]` equals (start + offset) modulo 4, where start is bits 1:0 of the captured address. Each advance therefore adds one modulo 4.
- R5: With `mode`=1 (interleaved), `addr_out[1:0]` equals start XOR offset.
- R6: After four advances from a load, `addr_out` returns to the loaded address, with no carry into bit 2 or above.
- R7: An advance steps the offset whatever the value of `sel_valid`.
- R8: At an edge with `clk_en`=0, the stored state holds, so `addr_out` is unchanged while `mode` is unchanged.
- R9: At an edge with `clk_en`=1, `adv_ld`=0 and `sel_valid`=0, no load happens and the offset holds, so `addr_out` is unchanged while `mode` is unchanged.
- R10: `mode` is applied to the stored offset without a register, so changing `mode` mid-burst shows the other order's beat for the same offset in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable; low freezes all state |
| adv_ld | input | 1 | 1 = advance burst, 0 = load new address |
| sel_valid | input | 1 | Chip selected; qualifies a load |
| mode | input | 1 | Beat order: 0 linear, 1 interleaved |
| ext_addr | input | ADDR_W | External address captured on a load |
| addr_out | output | ADDR_W | Current access address |

## Verification
Load, advance, hold and reset results appear on `addr_out` one rising edge after the stimulus, because the start and offset registers are the only state on that path. A mode change shows up combinationally in the same cycle. The bench drives inputs on the falling edge, lets one rising edge pass, and compares `addr_out` at the next falling edge with a bench model. For a mode-only change, it compares after a short settling delay with no clock edge in between.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } op_e;

    function automatic op_e decode_op(input logic en, input logic adv, input logic sel);
        op_e op;
        op = OP_HOLD;
        if (en) begin
            if (adv)      op = OP_STEP;
            else if (sel) op = OP_LOAD;
        end
        return op;
    endfunction

    function automatic beat_t map_beat(input order_e ord, input beat_t start, input beat_t off);
        beat_t b;
        if (ord == ORDER_INTERLEAVE) b = start ^ off;
        else                         b = start + off;
        return b;
    endfunction

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] base_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (op == OP_LOAD) begin
            base_q <= ext_addr;
        end
    end

endmodule

// File: rtl/burst_offset_ctr.sv
module burst_offset_ctr
    import burst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_e   op,
    output beat_t off_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= '0;
        end else begin
            unique case (op)
                OP_LOAD: off_q <= '0;
                OP_STEP: off_q <= off_q + beat_t'(1);
                default: off_q <= off_q;
            endcase
        end
    end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] base,
    input  beat_t             off,
    input  order_e            ord,
    output logic [ADDR_W-1:0] addr
);

    localparam int UP_W = ADDR_W - BEAT_W;

    beat_t low_beat;

    always_comb begin
        low_beat = map_beat(ord, base[BEAT_W-1:0], off);
    end

    generate
        if (UP_W > 0) begin : g_upper
            assign addr = {base[ADDR_W-1:BEAT_W], low_beat};
        end else begin : g_beat_only
            assign addr = low_beat[ADDR_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              adv_ld,
    input  logic              sel_valid,
    input  logic              mode,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] addr_out
);

    op_e               op;
    logic [ADDR_W-1:0] base_q;
    beat_t             off_q;
    order_e            ord;

    always_comb begin
        op  = decode_op(clk_en, adv_ld, sel_valid);
        ord = order_e'(mode);
    end

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .ext_addr (ext_addr),
        .base_q   (base_q)
    );

    burst_offset_ctr u_off (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .off_q (off_q)
    );

    burst_order_map #(.ADDR_W(ADDR_W)) u_map (
        .base (base_q),
        .off  (off_q),
        .ord  (ord),
        .addr (addr_out)
    );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_en,
    input logic              adv_ld,
    input logic              sel_valid,
    input logic              mode,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] addr_out
);

    AST_LOAD_CAPTURES: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !adv_ld && sel_valid) |=> addr_out == $past(ext_addr)); // R2

    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
        (clk_en && adv_ld) |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])); // R3

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (clk_en && adv_ld && !mode) |=>
        (mode || addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1))); // R4

    AST_FROZEN_NO_EN: assert property (@(posedge clk) disable iff (rst)
        (!clk_en) |=> (mode != $past(mode) || addr_out == $past(addr_out))); // R8

    AST_DESEL_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !adv_ld && !sel_valid) |=>
        (mode != $past(mode) || addr_out == $past(addr_out))); // R9

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clk_en    (clk_en),
    .adv_ld    (adv_ld),
    .sel_valid (sel_valid),
    .mode      (mode),
    .ext_addr  (ext_addr),
    .addr_out  (addr_out)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

    localparam int W = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clk_en = 1'b0;
    logic         adv_ld = 1'b0;
    logic         sel_valid = 1'b0;
    logic         mode = 1'b0;
    logic [W-1:0] ext_addr = '0;
    logic [W-1:0] addr_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [W-1:0] m_base = '0;
    logic [1:0]   m_off  = '0;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .adv_ld    (adv_ld),
        .sel_valid (sel_valid),
        .mode      (mode),
        .ext_addr  (ext_addr),
        .addr_out  (addr_out)
    );

    function automatic logic [W-1:0] expect_addr(input logic [W-1:0] b, input logic [1:0] o,
                                                 input logic m);
        logic [1:0] lo;
        lo = m ? (b[1:0] ^ o) : 2'(b[1:0] + o);
        return {b[W-1:2], lo};
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Entered at a falling edge; one rising edge, model update, compare at next falling edge.
    task automatic cycle(input logic r, input logic en, input logic adv, input logic sel,
                         input logic m, input logic [W-1:0] a, input string tag);
        rst = r; clk_en = en; adv_ld = adv; sel_valid = sel; mode = m; ext_addr = a;
        @(posedge clk);
        if (r) begin
            m_base = '0; m_off = '0;
        end else if (en && adv) begin
            m_off = m_off + 2'd1;
        end else if (en && sel) begin
            m_base = a; m_off = '0;
        end
        @(negedge clk);
        check(tag, addr_out, expect_addr(m_base, m_off, m));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] a;
        logic [W-1:0] snap;
        void'($urandom(32'd7321));
        @(negedge clk);
        cycle(1, 0, 0, 0, 0, 20'hABCDE, "R1");
        cycle(1, 1, 0, 1, 0, 20'h12345, "R1");
        check("R1", addr_out, '0);

        // R2 load, then R4/R6 linear wrap from start 3 with bit 2 set
        a = 20'h5A5A7;
        cycle(0, 1, 0, 1, 0, a, "R2");
        check("R2", addr_out, a);
        cycle(0, 1, 1, 1, 0, '0, "R4");
        check("R4", addr_out, 20'h5A5A4);
        cycle(0, 1, 1, 1, 0, '0, "R3");
        check("R3", addr_out, 20'h5A5A5);
        cycle(0, 1, 1, 1, 0, '0, "R4");
        check("R4", addr_out, 20'h5A5A6);
        cycle(0, 1, 1, 1, 0, '0, "R6");
        check("R6", addr_out, a);

        // R5 interleaved from start 2: 2,3,0,1, then back
        a = 20'hFFFF6;
        cycle(0, 1, 0, 1, 1, a, "R2");
        cycle(0, 1, 1, 1, 1, '0, "R5");
        check("R5", addr_out, 20'hFFFF7);
        cycle(0, 1, 1, 1, 1, '0, "R5");
        check("R5", addr_out, 20'hFFFF4);
        cycle(0, 1, 1, 1, 1, '0, "R5");
        check("R5", addr_out, 20'hFFFF5);
        cycle(0, 1, 1, 1, 1, '0, "R6");
        check("R6", addr_out, a);

        // R7 advance while not selected
        a = 20'h00010;
        cycle(0, 1, 0, 1, 0, a, "R2");
        cycle(0, 1, 1, 0, 0, '0, "R7");
        check("R7", addr_out, 20'h00011);

        // R8 clock enable low holds, even with load requested
        snap = addr_out;
        cycle(0, 0, 0, 1, 0, 20'h77777, "R8");
        check("R8", addr_out, snap);
        cycle(0, 0, 1, 1, 0, '0, "R8");
        check("R8", addr_out, snap);

        // R9 load while deselected is ignored
        cycle(0, 1, 0, 0, 0, 20'h33333, "R9");
        check("R9", addr_out, snap);

        // R10 mode change mid-burst: start 1, offset 2 -> linear 3, interleaved 3; use offset 1
        a = 20'h00101;
        cycle(0, 1, 0, 1, 0, a, "R2");
        cycle(0, 1, 1, 1, 0, '0, "R4");
        check("R4", addr_out, 20'h00102);
        clk_en = 1'b0; mode = 1'b1;
        #1;
        check("R10", addr_out, 20'h00100);
        @(negedge clk);
        mode = 1'b0;
        #1;
        check("R10", addr_out, 20'h00102);
        @(negedge clk);

        // Random traffic
        for (int i = 0; i < 400; i++) begin
            logic en, adv, sel, m;
            en  = ($urandom % 8) != 0;
            adv = $urandom[0];
            sel = ($urandom % 4) != 0;
            m   = ($urandom % 16) == 0 ? ~mode : mode;
            cycle(0, en, adv, sel, m, W'($urandom), m ? "R5" : "R4");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule